// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two bidirectional 16-bit ports, A and B. Each direction has its own bank of storage that can either follow its source port or hold a captured word. Three active-low controls govern each direction:

- a direction enable, which gates everything in that direction;
- a latch enable, which selects follow or hold;
- an output enable, which lets the held or followed word drive the opposite port.

The controls are split by byte lane. Bits 7:0 and bits 15:8 each have a full set of six controls. The block can therefore serve as two independent 8-bit transceivers, or as one 16-bit transceiver when the lane controls are tied together.

The port pins are modelled with separate input-data, output-data and per-bit output-enable vectors, so the block fits inside a synchronous chip. Storage is updated on the rising clock edge. While a latch is transparent, the output path bypasses storage, so the driven value follows the input within the same cycle. Port value and reset behaviour:

- When a port is not driven, its output-data bits read zero.
- Synchronous active-high reset clears every stored word.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: After reset every stored word is zero; enabling a direction's output with its latch enable high then drives 0x0000 on the opposite port.
- R2: With a direction's direction enable and latch enable both low (and its source port not driven by the block), the opposite port's output data equals the source port's input data in the same cycle.
- R3: A direction's stored word is the source data present at the last rising clock edge with its latch enable low; once the latch enable is high, later source changes do not alter the driven value.
- R4: With a direction enable high, that direction neither captures (even with its latch enable low) nor drives: its output-enable bits are 0 and its output data is 0.
- R5: With an output enable high, that direction's output-enable bits and output data are 0, while capture still proceeds; clearing the output enable later drives the captured word.
- R6: A direction drives exactly when its direction enable and output enable are both low; the lane's eight output-enable bits are then all 1 and its output data is the latch view.
- R7: The B-to-A direction behaves the same as A-to-B, using its own three controls, with B as the source port and A as the driven port.
- R8: Lane 0 (bits 7:0) and lane 1 (bits 15:8) are controlled only by their own control bit (index 0 and index 1 of each control vector), and neither lane affects the other.
- R9: While the block drives a port in a lane, the latch that takes its input from that port holds its stored word and does not follow the port's input data.
- R10: Every one of the 64 combinations of the six controls of a lane gives outputs that match a behavioural model of R1 to R9, on both lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all storage |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data driven onto port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data driven onto port B |
| b_oe | output | 16 | Per-bit drive enable for port B |
| ab_dir_n | input | 2 | A-to-B direction enable per lane, active low |
| ab_le_n | input | 2 | A-to-B latch enable per lane, active low |
| ab_oe_n | input | 2 | A-to-B output enable per lane, active low |
| ba_dir_n | input | 2 | B-to-A direction enable per lane, active low |
| ba_le_n | input | 2 | B-to-A latch enable per lane, active low |
| ba_oe_n | input | 2 | B-to-A output enable per lane, active low |

## Verification
Drive enables and transparent data reach the outputs in the same cycle as the stimulus, with no register in between. A captured word becomes visible only after the next rising edge has passed with its latch enable low. The bench changes every input at the falling edge and samples 1 ns later, so each check sees a state in which either zero edges or exactly one edge has elapsed since the stimulus. A reference model updated on the same rising edges supplies the expected values for the full control sweep, and the directed steps use literal words worked out edge by edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned DEF_LANE_W = 8;
    localparam int unsigned DEF_LANES  = 2;

    typedef struct packed {
        logic dir_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;

    function automatic logic path_follows(input dir_ctrl_t c, input logic blocked);
        return !c.dir_n && !c.le_n && !blocked;
    endfunction

    function automatic logic path_drives(input dir_ctrl_t c);
        return !c.dir_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned W = DEF_LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic         blocked,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);

    logic [W-1:0] store;
    logic         follow;
    logic [W-1:0] view;

    assign follow = path_follows(ctrl, blocked);
    assign view   = follow ? din : store;
    assign drive  = path_drives(ctrl);
    assign dout   = drive ? view : '0;

    always_ff @(posedge clk) begin
        if (rst)
            store <= '0;
        else if (follow)
            store <= din;
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (store == '0));

    a_r4_dir_off_holds: assert property (@(posedge clk) disable iff (rst)
        (!rst && ctrl.dir_n) |=> $stable(store));

    a_r3_le_high_holds: assert property (@(posedge clk) disable iff (rst)
        (!rst && ctrl.le_n) |=> $stable(store));

    a_r9_blocked_holds: assert property (@(posedge clk) disable iff (rst)
        (!rst && blocked) |=> $stable(store));

    a_r2_follow_passes: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.dir_n && !ctrl.le_n && !ctrl.oe_n && !blocked) |-> (dout == din));

    a_r5_oe_off_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.oe_n |-> (dout == '0 && !drive));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned W = DEF_LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ab_ctrl,
    input  dir_ctrl_t    ba_ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic ab_drive;
    logic ba_drive;

    // A-to-B path: source port A, blocked while the block drives port A
    xcvr_path #(.W(W)) ab_path_i (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ab_ctrl),
        .blocked (ba_drive),
        .din     (a_in),
        .dout    (b_out),
        .drive   (ab_drive)
    );

    // B-to-A path: source port B, blocked while the block drives port B
    xcvr_path #(.W(W)) ba_path_i (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ba_ctrl),
        .blocked (ab_drive),
        .din     (b_in),
        .dout    (a_out),
        .drive   (ba_drive)
    );

    assign b_oe = {W{ab_drive}};
    assign a_oe = {W{ba_drive}};

    a_r6_b_drive_full: assert property (@(posedge clk) disable iff (rst)
        (!ab_ctrl.dir_n && !ab_ctrl.oe_n) |-> (b_oe == {W{1'b1}}));

    a_r7_a_drive_full: assert property (@(posedge clk) disable iff (rst)
        (!ba_ctrl.dir_n && !ba_ctrl.oe_n) |-> (a_oe == {W{1'b1}}));

    a_r4_dir_off_no_drive: assert property (@(posedge clk) disable iff (rst)
        ab_ctrl.dir_n |-> (b_oe == '0 && b_out == '0));

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe,
    input  logic [LANES-1:0] ab_dir_n,
    input  logic [LANES-1:0] ab_le_n,
    input  logic [LANES-1:0] ab_oe_n,
    input  logic [LANES-1:0] ba_dir_n,
    input  logic [LANES-1:0] ba_le_n,
    input  logic [LANES-1:0] ba_oe_n
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dir_ctrl_t ab_c;
        dir_ctrl_t ba_c;

        assign ab_c = '{dir_n: ab_dir_n[l], le_n: ab_le_n[l], oe_n: ab_oe_n[l]};
        assign ba_c = '{dir_n: ba_dir_n[l], le_n: ba_le_n[l], oe_n: ba_oe_n[l]};

        xcvr_lane #(.W(LANE_W)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .ab_ctrl (ab_c),
            .ba_ctrl (ba_c),
            .a_in    (a_in [l*LANE_W +: LANE_W]),
            .b_in    (b_in [l*LANE_W +: LANE_W]),
            .a_out   (a_out[l*LANE_W +: LANE_W]),
            .a_oe    (a_oe [l*LANE_W +: LANE_W]),
            .b_out   (b_out[l*LANE_W +: LANE_W]),
            .b_oe    (b_oe [l*LANE_W +: LANE_W])
        );

        // R8: a lane's drive enables follow only its own control bits
        a_r8_lane_own_ctrl: assert property (@(posedge clk) disable iff (rst)
            (ab_dir_n[l] || ab_oe_n[l]) |-> (b_oe[l*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: tb/bidir_latch_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_tb_top;

    localparam int W  = 8;
    localparam int NL = 2;
    localparam int BW = W * NL;

    logic          clk = 1'b0;
    logic          rst;
    logic [BW-1:0] a_in, b_in;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;
    logic [NL-1:0] ab_dir_n, ab_le_n, ab_oe_n, ba_dir_n, ba_le_n, ba_oe_n;

    always #2 clk = ~clk;

    bidir_latch_xcvr dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_dir_n(ab_dir_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_dir_n(ba_dir_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    typedef struct {
        logic [BW-1:0] ao, aoe, bo, boe;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    event sb_ev;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Behavioural reference storage, written only from the requirements
    logic [W-1:0] m_ab [NL];
    logic [W-1:0] m_ba [NL];

    function automatic logic drv_ab(int l); return !ab_dir_n[l] && !ab_oe_n[l]; endfunction
    function automatic logic drv_ba(int l); return !ba_dir_n[l] && !ba_oe_n[l]; endfunction
    function automatic logic fol_ab(int l); return !ab_dir_n[l] && !ab_le_n[l] && !drv_ba(l); endfunction
    function automatic logic fol_ba(int l); return !ba_dir_n[l] && !ba_le_n[l] && !drv_ab(l); endfunction

    always @(posedge clk) begin
        for (int l = 0; l < NL; l++) begin
            if (rst) begin
                m_ab[l] <= '0;
                m_ba[l] <= '0;
            end else begin
                if (fol_ab(l)) m_ab[l] <= a_in[l*W +: W];
                if (fol_ba(l)) m_ba[l] <= b_in[l*W +: W];
            end
        end
    end

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (a_out !== e.ao || a_oe !== e.aoe || b_out !== e.bo || b_oe !== e.boe) begin
                    n_fail++;
                    $display("FAIL %s: got a_out=%h a_oe=%h b_out=%h b_oe=%h exp a_out=%h a_oe=%h b_out=%h b_oe=%h",
                             e.tag, a_out, a_oe, b_out, b_oe, e.ao, e.aoe, e.bo, e.boe);
                end
            end
        end
    end

    task automatic push_exp(input logic [BW-1:0] ao, aoe, bo, boe, input string tag);
        exp_t e;
        e.ao = ao; e.aoe = aoe; e.bo = bo; e.boe = boe; e.tag = tag;
        sb_q.push_back(e);
        -> sb_ev;
        #0.1;
    endtask

    task automatic push_model(input string tag);
        logic [BW-1:0] ao, aoe, bo, boe;
        for (int l = 0; l < NL; l++) begin
            logic [W-1:0] vab, vba;
            vab = fol_ab(l) ? a_in[l*W +: W] : m_ab[l];
            vba = fol_ba(l) ? b_in[l*W +: W] : m_ba[l];
            bo [l*W +: W] = drv_ab(l) ? vab : '0;
            boe[l*W +: W] = {W{drv_ab(l)}};
            ao [l*W +: W] = drv_ba(l) ? vba : '0;
            aoe[l*W +: W] = {W{drv_ba(l)}};
        end
        push_exp(ao, aoe, bo, boe, tag);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        ab_dir_n = '1; ab_le_n = '1; ab_oe_n = '1;
        ba_dir_n = '1; ba_le_n = '1; ba_oe_n = '1;
        repeat (3) @(posedge clk);
        step(); rst = 1'b0;

        // R1: reset state visible through an enabled output with latch holding
        step(); ab_dir_n = 2'b00; ab_oe_n = 2'b00; ab_le_n = 2'b11; a_in = 16'hFFFF;
        #1 push_exp(16'h0000, 16'h0000, 16'h0000, 16'hFFFF, "R1 reset zero");

        // R2: transparent, same-cycle follow
        step(); ab_le_n = 2'b00; a_in = 16'h1234;
        #1 push_exp(16'h0000, 16'h0000, 16'h1234, 16'hFFFF, "R2 transparent");

        // R3: latch enable rises, later data ignored
        step(); ab_le_n = 2'b11; a_in = 16'hABCD;
        #1 push_exp(16'h0000, 16'h0000, 16'h1234, 16'hFFFF, "R3 capture hold");

        // R4: direction off: no drive, no capture even with latch enable low
        step(); ab_dir_n = 2'b11; ab_le_n = 2'b00; a_in = 16'h5555;
        #1 push_exp(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R4 dir off quiet");
        step(); ab_dir_n = 2'b00; ab_le_n = 2'b11;
        #1 push_exp(16'h0000, 16'h0000, 16'h1234, 16'hFFFF, "R4 dir off no capture");

        // R5: output enable off still captures
        step(); ab_oe_n = 2'b11; ab_le_n = 2'b00; a_in = 16'h0F0F;
        #1 push_exp(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R5 oe off quiet");
        step(); ab_oe_n = 2'b00; ab_le_n = 2'b11; a_in = 16'h7777;
        #1 push_exp(16'h0000, 16'h0000, 16'h0F0F, 16'hFFFF, "R5 captured while off");

        // R7: B-to-A mirror
        step(); ab_dir_n = 2'b11; ba_dir_n = 2'b00; ba_le_n = 2'b00; ba_oe_n = 2'b00; b_in = 16'h9876;
        #1 push_exp(16'h9876, 16'hFFFF, 16'h0000, 16'h0000, "R7 b to a");

        // R8: lane 0 transparent, lane 1 holding
        step(); ba_dir_n = 2'b11; ba_le_n = 2'b11; ba_oe_n = 2'b11;
        ab_dir_n = 2'b00; ab_oe_n = 2'b00; ab_le_n = 2'b10; a_in = 16'hEEEE;
        #1 push_exp(16'h0000, 16'h0000, 16'h0FEE, 16'hFFFF, "R8 lanes independent");
        step(); ab_oe_n = 2'b01;
        #1 push_exp(16'h0000, 16'h0000, 16'h0F00, 16'hFF00, "R8 lane0 oe off only");

        // R9: both directions driving; each latch ignores its driven port
        step(); ab_oe_n = 2'b00; ab_le_n = 2'b00; ba_dir_n = 2'b00; ba_oe_n = 2'b00; ba_le_n = 2'b00;
        a_in = 16'h3333; b_in = 16'h4444;
        #1 push_exp(16'h9876, 16'hFFFF, 16'h0FEE, 16'hFFFF, "R9 driven port ignored");
        step(); ba_dir_n = 2'b11; ba_oe_n = 2'b11; ab_le_n = 2'b11;
        #1 push_exp(16'h0000, 16'h0000, 16'h0FEE, 16'hFFFF, "R9 no capture after");

        // R10: every control combination on each lane against the model
        for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < 64; c++) begin
                step();
                ab_dir_n[l] = c[0]; ab_le_n[l] = c[1]; ab_oe_n[l] = c[2];
                ba_dir_n[l] = c[3]; ba_le_n[l] = c[4]; ba_oe_n[l] = c[5];
                ab_dir_n[1-l] = c[2]; ab_le_n[1-l] = c[0]; ab_oe_n[1-l] = 1'b0;
                ba_dir_n[1-l] = 1'b1; ba_le_n[1-l] = c[1]; ba_oe_n[1-l] = 1'b1;
                a_in = 16'h5A3C ^ (16'(c) * 16'h0301);
                b_in = 16'hC3A5 ^ (16'(c) * 16'h0107);
                #1 push_model($sformatf("R10 lane%0d ctrl%0d", l, c));
            end
        end

        step();
        #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule